// File: doc/BRIEF.md
# Sub-blocked direct-mapped write-through cache controller

This block sits between a processor load/store port and a word-wide memory port. It is a direct-mapped cache in which every line keeps a single address tag but is divided into several sub-blocks. Each sub-block has its own valid bit and holds one word.

On a lookup, the tag and the addressed sub-block's valid bit give three outcomes:
- **Tag matches and the sub-block is valid:** the request is a hit.
- **Tag matches and the sub-block is not valid:** only that one word is fetched.
- **Tag differs:** the line is reassigned to the new tag, the fetched sub-block becomes its only valid part, and every other sub-block is dropped.

All writes go through to memory. A write that covers a whole sub-block can claim a sub-block, or even a whole line, without any fetch. A narrower write updates the cache only on a hit.

The processor side is a ready/request handshake. Each request carries a byte address, a write flag and a size code. Requests are handled one at a time. Read data returns with a one-cycle valid pulse. The memory side holds a request until the memory acknowledges it, and one request moves exactly one word.

Top module: `subblk_cache`

## Requirements
- R1: After reset every sub-block is invalid, `cpu_ready` is 1, and `cpu_rvalid` and `mem_req` are 0.
- R2: A read is a hit when the line's tag equals the address tag and that sub-block is valid. Address bits are [1:0] byte, [3:2] sub-block, [9:4] line and [15:10] tag. On a hit, `cpu_rvalid` pulses for one cycle after the edge following the accepting edge. It carries the cached word, and no memory request is made.
- R3: A read whose tag matches but whose sub-block is invalid issues exactly one memory read. That read targets the word-aligned address of that sub-block. The sub-block then becomes valid, and the line's other sub-blocks keep their state.
- R4: A read whose tag differs fetches only the addressed sub-block and installs the new tag. After the fill, that sub-block is the only valid one in the line. A line with no valid sub-block counts as a tag mismatch.
- R5: For a read miss, `cpu_ready` stays 0 from the accepting edge until the edge that samples `mem_ack`. On that edge, `cpu_rvalid` rises together with `cpu_rdata` = `mem_rdata`, and `cpu_ready` returns to 1.
- R6: Every write issues exactly one memory write with the word-aligned address and `cpu_wdata` unchanged. `cpu_ready` returns to 1 on the edge that samples `mem_ack`.
- R7: A write hit merges the enabled byte lanes into the cached word and leaves the other lanes unchanged.
- R8: A full-word write with a tag match and an invalid sub-block stores the data and marks that sub-block valid, with no memory read.
- R9: A full-word write with a tag mismatch installs the new tag and marks only the written sub-block valid, with no memory read.
- R10: A write narrower than a word that is not a hit leaves the cache unchanged, so a later read of that word misses.
- R11: `cpu_size` selects the lanes:
  - 0 selects one byte, lane = address[1:0].
  - 1 selects a half-word, lanes {address[1],0} and {address[1],1}.
  - 2 and 3 select the full word, all four lanes.

  `mem_be` carries this mask on writes and is all ones on reads.
- R12: While `mem_req` is 1 without `mem_ack`, `mem_req`, `mem_we` and `mem_addr` stay unchanged on the next cycle, and `cpu_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, accepted when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Access size code (R11) |
| cpu_addr | input | ADDR_W (16) | Byte address |
| cpu_wdata | input | WORD_W (32) | Write data, already placed in its byte lanes |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_rvalid | output | 1 | One-cycle read data strobe |
| cpu_rdata | output | WORD_W (32) | Read word |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W (16) | Word-aligned byte address |
| mem_be | output | WORD_W/8 (4) | Byte lane enables |
| mem_wdata | output | WORD_W (32) | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | WORD_W (32) | Memory read data, valid with `mem_ack` |

## Verification
Two operations land on the same clock edge when a fill completes:
- the tag being replaced together with the sibling valid bits being cleared;
- the fetched word being written into the data array and returned to the processor.

The bench provokes this in two steps. It first validates several sub-blocks of one line. It then reads the same line index under a different tag, and changes backing memory behind the cache's back. The outcome is judged against a behavioural reference model, per cycle on `cpu_ready`, `cpu_rvalid` and `mem_req`, and per request on the returned word. Stale cached words versus fresh memory words show which sibling sub-blocks survived the replacement. A seeded mix of reads and narrow and wide writes over a few colliding tags then repeats this interplay with memory latencies of zero to two cycles.

// File: rtl/subblk_cache_pkg.sv
package subblk_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_FILL  = 2'd2,
    ST_WRITE = 2'd3
  } sbc_state_e;

endpackage

// File: rtl/subblk_tag_store.sv
module subblk_tag_store #(
  parameter int LINES = 64,
  parameter int SUBS  = 4,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(LINES),
  localparam int SUB_W = $clog2(SUBS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic [SUBS-1:0]  rd_vld,
  input  logic             upd_en,
  input  logic             repl_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [SUB_W-1:0] upd_sub,
  input  logic [TAG_W-1:0] upd_tag
);

  logic [TAG_W-1:0] tags [LINES];
  logic [SUBS-1:0]  vld  [LINES];

  // tag memory: plain synchronous RAM
  always_ff @(posedge clk) begin
    if (repl_en) tags[upd_idx] <= upd_tag;
    if (rd_en)   rd_tag <= tags[rd_idx];
  end

  // per-sub-block valid flags kept in flops so reset can clear them
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < LINES; l++) vld[l] <= '0;
      rd_vld <= '0;
    end else begin
      if (upd_en) begin
        if (repl_en) begin
          vld[upd_idx] <= '0;
          vld[upd_idx][upd_sub] <= 1'b1;
        end else begin
          vld[upd_idx][upd_sub] <= 1'b1;
        end
      end
      if (rd_en) rd_vld <= vld[rd_idx];
    end
  end

  // R3: a fill or install leaves its sub-block valid
  p_fill_sets_valid_r3: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> vld[$past(upd_idx)][$past(upd_sub)]);

  // R4 / R9: a replacement leaves exactly one valid sub-block in the line
  p_replace_single_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_en && repl_en) |=> ($countones(vld[$past(upd_idx)]) == 1));

  // R9: a tag is only rewritten together with a valid update
  p_repl_with_upd_r9: assert property (@(posedge clk) disable iff (rst)
    repl_en |-> upd_en);

endmodule

// File: rtl/subblk_data_store.sv
module subblk_data_store #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 32,
  localparam int BYTES = WORD_W / 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic [BYTES-1:0]  wr_be,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data
);

  logic [WORD_W-1:0] ram [DEPTH];

  // byte-enabled single-clock RAM with registered read
  always_ff @(posedge clk) begin
    for (int b = 0; b < BYTES; b++) begin
      if (wr_be[b]) ram[wr_addr][b*8 +: 8] <= wr_data[b*8 +: 8];
    end
    if (rd_en) rd_data <= ram[rd_addr];
  end

endmodule

// File: rtl/subblk_ctrl.sv
module subblk_ctrl
  import subblk_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINES  = 64,
  parameter int SUBS   = 4,
  parameter int WORD_W = 32,
  localparam int BYTES = WORD_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int IDX_W = $clog2(LINES),
  localparam int SUB_W = $clog2(SUBS),
  localparam int TAG_W = ADDR_W - IDX_W - SUB_W - OFF_W,
  localparam int WA_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              st_rd_en,
  output logic [IDX_W-1:0]  st_rd_idx,
  output logic [SUB_W-1:0]  st_rd_sub,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [SUBS-1:0]   st_vld,
  input  logic [WORD_W-1:0] st_data,
  output logic              upd_en,
  output logic              repl_en,
  output logic [IDX_W-1:0]  upd_idx,
  output logic [SUB_W-1:0]  upd_sub,
  output logic [TAG_W-1:0]  upd_tag,
  output logic [BYTES-1:0]  dat_be,
  output logic [WORD_W-1:0] dat_wd
);

  // lane mask from size code and byte offset (R11)
  function automatic logic [BYTES-1:0] lane_mask(input logic [1:0] sz,
                                                 input logic [OFF_W-1:0] off);
    int nb;
    int base;
    logic [BYTES-1:0] m;
    nb   = (int'(sz) >= OFF_W) ? BYTES : (1 << sz);
    base = (int'(off) / nb) * nb;
    for (int b = 0; b < BYTES; b++) m[b] = (b >= base) && (b < base + nb);
    return m;
  endfunction

  sbc_state_e        st;
  logic              rdy_q, rvalid_q, mreq_q, mwe_q, we_q, full_q, match_q;
  logic [WA_W-1:0]   a_q;
  logic [BYTES-1:0]  be_q, mbe_q;
  logic [WORD_W-1:0] wd_q, rdata_q, mwd_q;
  logic [ADDR_W-1:0] maddr_q;

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [SUB_W-1:0]  a_sub;
  logic              line_live, match, sub_hit;

  assign a_sub = a_q[0 +: SUB_W];
  assign a_idx = a_q[SUB_W +: IDX_W];
  assign a_tag = a_q[WA_W-1 -: TAG_W];

  // lookup outcome; an empty line never counts as a tag match
  assign line_live = |st_vld;
  assign match     = line_live && (st_tag == a_tag);
  assign sub_hit   = match && st_vld[a_sub];

  // store read port driven straight from the accepted request
  assign st_rd_en  = rdy_q && cpu_req;
  assign st_rd_idx = cpu_addr[OFF_W+SUB_W +: IDX_W];
  assign st_rd_sub = cpu_addr[OFF_W +: SUB_W];

  assign upd_idx = a_idx;
  assign upd_sub = a_sub;
  assign upd_tag = a_tag;

  // store write controls
  always_comb begin
    upd_en  = 1'b0;
    repl_en = 1'b0;
    dat_be  = '0;
    dat_wd  = wd_q;
    if (st == ST_LOOK && we_q) begin
      if (sub_hit) begin
        dat_be = be_q;
      end else if (full_q) begin
        dat_be  = '1;
        upd_en  = 1'b1;
        repl_en = !match;
      end
    end else if (st == ST_FILL && mem_ack) begin
      dat_be  = '1;
      dat_wd  = mem_rdata;
      upd_en  = 1'b1;
      repl_en = !match_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      rdy_q    <= 1'b1;
      rvalid_q <= 1'b0;
      mreq_q   <= 1'b0;
      mwe_q    <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      case (st)
        ST_IDLE: if (cpu_req) begin
          a_q    <= cpu_addr[ADDR_W-1:OFF_W];
          we_q   <= cpu_we;
          be_q   <= lane_mask(cpu_size, cpu_addr[OFF_W-1:0]);
          full_q <= (int'(cpu_size) >= OFF_W);
          wd_q   <= cpu_wdata;
          rdy_q  <= 1'b0;
          st     <= ST_LOOK;
        end
        ST_LOOK: begin
          match_q <= match;
          maddr_q <= {a_q, {OFF_W{1'b0}}};
          mwd_q   <= wd_q;
          mbe_q   <= we_q ? be_q : '1;
          if (!we_q && sub_hit) begin
            rdata_q  <= st_data;
            rvalid_q <= 1'b1;
            rdy_q    <= 1'b1;
            st       <= ST_IDLE;
          end else begin
            mreq_q <= 1'b1;
            mwe_q  <= we_q;
            st     <= we_q ? ST_WRITE : ST_FILL;
          end
        end
        ST_FILL: if (mem_ack) begin
          mreq_q   <= 1'b0;
          rdata_q  <= mem_rdata;
          rvalid_q <= 1'b1;
          rdy_q    <= 1'b1;
          st       <= ST_IDLE;
        end
        ST_WRITE: if (mem_ack) begin
          mreq_q <= 1'b0;
          rdy_q  <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready  = rdy_q;
  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = rdata_q;
  assign mem_req    = mreq_q;
  assign mem_we     = mwe_q;
  assign mem_addr   = maddr_q;
  assign mem_be     = mbe_q;
  assign mem_wdata  = mwd_q;

  // R12: an unanswered memory request is held steady
  p_mem_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R5 / R12: the processor is never offered ready while memory is busy
  p_busy_no_ready_r5: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);

  // R2: read strobe is a single-cycle pulse
  p_rvalid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |=> !cpu_rvalid);

  // R2: a read hit answers at once without touching memory
  p_hit_no_mem_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOK && !we_q && sub_hit) |=> (cpu_rvalid && !mem_req));

  // R6: every write leaves as a memory write
  p_write_through_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOK && we_q) |=> (mem_req && mem_we));

  // R5: the acknowledged fill is returned on the same edge
  p_fill_answer_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FILL && mem_ack) |=> (cpu_rvalid && cpu_ready));

endmodule

// File: rtl/subblk_cache.sv
module subblk_cache #(
  parameter int ADDR_W = 16,
  parameter int LINES  = 64,
  parameter int SUBS   = 4,
  parameter int WORD_W = 32,
  localparam int BYTES = WORD_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int IDX_W = $clog2(LINES),
  localparam int SUB_W = $clog2(SUBS),
  localparam int TAG_W = ADDR_W - IDX_W - SUB_W - OFF_W,
  localparam int DEPTH = LINES * SUBS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);

  logic              st_rd_en;
  logic [IDX_W-1:0]  st_rd_idx;
  logic [SUB_W-1:0]  st_rd_sub;
  logic [TAG_W-1:0]  st_tag;
  logic [SUBS-1:0]   st_vld;
  logic [WORD_W-1:0] st_data;
  logic              upd_en, repl_en;
  logic [IDX_W-1:0]  upd_idx;
  logic [SUB_W-1:0]  upd_sub;
  logic [TAG_W-1:0]  upd_tag;
  logic [BYTES-1:0]  dat_be;
  logic [WORD_W-1:0] dat_wd;

  subblk_ctrl #(
    .ADDR_W(ADDR_W), .LINES(LINES), .SUBS(SUBS), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .st_rd_en(st_rd_en), .st_rd_idx(st_rd_idx), .st_rd_sub(st_rd_sub),
    .st_tag(st_tag), .st_vld(st_vld), .st_data(st_data),
    .upd_en(upd_en), .repl_en(repl_en), .upd_idx(upd_idx),
    .upd_sub(upd_sub), .upd_tag(upd_tag),
    .dat_be(dat_be), .dat_wd(dat_wd)
  );

  subblk_tag_store #(
    .LINES(LINES), .SUBS(SUBS), .TAG_W(TAG_W)
  ) u_tags (
    .clk(clk), .rst(rst),
    .rd_en(st_rd_en), .rd_idx(st_rd_idx),
    .rd_tag(st_tag), .rd_vld(st_vld),
    .upd_en(upd_en), .repl_en(repl_en),
    .upd_idx(upd_idx), .upd_sub(upd_sub), .upd_tag(upd_tag)
  );

  subblk_data_store #(
    .DEPTH(DEPTH), .WORD_W(WORD_W)
  ) u_data (
    .clk(clk),
    .rd_en(st_rd_en), .rd_addr({st_rd_idx, st_rd_sub}), .rd_data(st_data),
    .wr_be(dat_be), .wr_addr({upd_idx, upd_sub}), .wr_data(dat_wd)
  );

endmodule

// File: tb/subblk_cache_bench.sv
`timescale 1ns/1ps
module subblk_cache_bench;

  localparam int AW = 16;
  localparam int NL = 64;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  subblk_cache u_subblk_cache (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int nreads = 0;
  int nwrites = 0;
  int wcnt = 0;
  bit done = 0;

  // backing memory, word addressed
  logic [31:0] bmem [int];

  // reference cache contents
  int unsigned m_tag [NL];
  bit          m_vld [NL][NS];
  logic [31:0] m_dat [NL][NS];

  function automatic logic [31:0] mem_get(input int wa);
    if (bmem.exists(wa)) return bmem[wa];
    return (wa * 32'h0100_0193) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? n[b*8 +: 8] : o[b*8 +: 8];
    return r;
  endfunction

  // lane mask per R11
  function automatic logic [3:0] lanes(input logic [1:0] sz, input logic [1:0] off);
    if (sz == 2'd0) return 4'b0001 << off;
    if (sz == 2'd1) return off[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [31:0] v);
    bmem[int'(a >> 2)] = v;
  endtask

  // memory responder: acknowledges after lat idle cycles
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        if (mem_we) begin
          bmem[int'(mem_addr >> 2)] = merge(mem_get(int'(mem_addr >> 2)), mem_wdata, mem_be);
          nwrites++;
        end else begin
          mem_rdata <= mem_get(int'(mem_addr >> 2));
          nreads++;
        end
        mem_ack <= 1'b1;
      end else begin
        wcnt = wcnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // one processor operation, checked against the model on every cycle
  task automatic op(input bit we, input logic [15:0] a, input logic [1:0] sz,
                    input logic [31:0] wd, input string rq);
    int t, ix, s, n, r0, w0;
    bit live, match, hit, full, memop;
    logic [3:0] be;
    logic [31:0] exp_rd;
    t = int'(a[15:10]); ix = int'(a[9:4]); s = int'(a[3:2]);
    live = 0;
    for (int k = 0; k < NS; k++) live |= m_vld[ix][k];
    match = live && (m_tag[ix] == t);
    hit   = match && m_vld[ix][s];
    full  = (sz >= 2);
    be    = lanes(sz, a[1:0]);
    memop = we || !hit;
    n     = memop ? 2 + lat : 1;
    exp_rd = '0;
    if (!we) begin
      exp_rd = hit ? m_dat[ix][s] : mem_get(int'(a >> 2));
      if (!hit) begin
        if (!match) begin
          m_tag[ix] = t;
          for (int k = 0; k < NS; k++) m_vld[ix][k] = 0;
        end
        m_vld[ix][s] = 1;
        m_dat[ix][s] = exp_rd;
      end
    end else begin
      if (hit) m_dat[ix][s] = merge(m_dat[ix][s], wd, be);
      else if (full) begin
        if (!match) begin
          m_tag[ix] = t;
          for (int k = 0; k < NS; k++) m_vld[ix][k] = 0;
        end
        m_vld[ix][s] = 1;
        m_dat[ix][s] = wd;
      end
    end
    r0 = nreads; w0 = nwrites;
    chk(cpu_ready === 1'b1, rq, "ready before request", 32'(cpu_ready), 1);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
    for (int j = 0; j <= n; j++) begin
      @(negedge clk);
      if (j == 0) cpu_req = 1'b0;
      chk(cpu_ready === (j == n), "R5", "ready per cycle", 32'(cpu_ready), 32'(j == n));
      chk(cpu_rvalid === (!we && j == n), "R2", "rvalid per cycle", 32'(cpu_rvalid),
          32'(!we && j == n));
      chk(mem_req === (memop && j >= 1 && j < n), "R12", "mem_req per cycle",
          32'(mem_req), 32'(memop && j >= 1 && j < n));
      if (mem_req) begin
        chk(mem_addr === {a[15:2], 2'b00}, rq, "mem_addr", 32'(mem_addr), 32'({a[15:2], 2'b00}));
        chk(mem_we === we, rq, "mem_we", 32'(mem_we), 32'(we));
        if (we) begin
          chk(mem_be === be, "R11", "mem_be", 32'(mem_be), 32'(be));
          chk(mem_wdata === wd, "R6", "mem_wdata", mem_wdata, wd);
        end else begin
          chk(mem_be === 4'hF, "R11", "read mem_be", 32'(mem_be), 32'hF);
        end
      end
      if (j == n && !we) chk(cpu_rdata === exp_rd, rq, "read data", cpu_rdata, exp_rd);
    end
    chk(nreads - r0 == (!we && !hit ? 1 : 0), rq, "memory reads",
        32'(nreads - r0), 32'(!we && !hit));
    chk(nwrites - w0 == (we ? 1 : 0), "R6", "memory writes", 32'(nwrites - w0), 32'(we));
  endtask

  function automatic logic [15:0] ad(input int t, input int ix, input int s, input int off);
    return {t[5:0], ix[5:0], s[1:0], off[1:0]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int unsigned seed;
    for (int l = 0; l < NL; l++) begin
      m_tag[l] = 0;
      for (int k = 0; k < NS; k++) begin m_vld[l][k] = 0; m_dat[l][k] = '0; end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(cpu_ready === 1'b1, "R1", "ready after reset", 32'(cpu_ready), 1);
    chk(cpu_rvalid === 1'b0, "R1", "rvalid after reset", 32'(cpu_rvalid), 0);
    chk(mem_req === 1'b0, "R1", "mem_req after reset", 32'(mem_req), 0);
    op(0, ad(1, 3, 0, 0), 2'd2, 0, "R1");          // empty line: miss
    op(0, ad(1, 3, 0, 0), 2'd2, 0, "R2");          // hit
    poke(ad(1, 3, 0, 0), 32'hDEAD_0001);
    poke(ad(1, 3, 1, 0), 32'hBEEF_0002);
    op(0, ad(1, 3, 0, 2), 2'd2, 0, "R2");          // stale cached word proves hit
    op(0, ad(1, 3, 1, 0), 2'd2, 0, "R3");          // sub-block miss
    op(0, ad(1, 3, 0, 0), 2'd2, 0, "R3");          // sibling kept
    lat = 2;
    op(0, ad(2, 3, 2, 0), 2'd2, 0, "R4");          // tag mismatch
    op(0, ad(2, 3, 0, 0), 2'd2, 0, "R4");          // sibling cleared: miss
    op(0, ad(2, 3, 2, 0), 2'd2, 0, "R5");
    lat = 0;
    op(1, ad(2, 3, 2, 1), 2'd0, 32'h0000_AB00, "R7");  // byte write hit
    poke(ad(2, 3, 2, 0), 32'h1111_1111);
    op(0, ad(2, 3, 2, 0), 2'd2, 0, "R7");
    op(1, ad(2, 3, 2, 2), 2'd1, 32'hC0DE_0000, "R11"); // half write hit
    op(0, ad(2, 3, 2, 0), 2'd2, 0, "R7");
    op(1, ad(2, 3, 3, 0), 2'd2, 32'h3333_3333, "R8");  // full write, invalid sub
    poke(ad(2, 3, 3, 0), 32'h0);
    op(0, ad(2, 3, 3, 0), 2'd2, 0, "R8");
    lat = 1;
    op(1, ad(5, 3, 1, 0), 2'd3, 32'h5555_AAAA, "R9");  // full write, mismatch
    poke(ad(5, 3, 1, 0), 32'h0);
    op(0, ad(5, 3, 1, 0), 2'd2, 0, "R9");
    op(0, ad(5, 3, 2, 0), 2'd2, 0, "R9");
    op(0, ad(2, 3, 3, 0), 2'd2, 0, "R9");
    op(1, ad(6, 7, 0, 3), 2'd0, 32'h7700_0000, "R10"); // narrow write, empty line
    op(0, ad(6, 7, 0, 0), 2'd2, 0, "R10");
    op(1, ad(6, 7, 2, 0), 2'd1, 32'h0000_4242, "R10"); // narrow write, invalid sub
    op(0, ad(6, 7, 2, 0), 2'd2, 0, "R10");
    // seeded mix over colliding tags
    seed = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      seed = seed * 32'd1103515245 + 32'd12345;
      lat = int'(seed[30:29]) % 3;
      a = ad(1 + int'(seed[9:8]) % 3, 5 + int'(seed[10]), int'(seed[12:11]),
             int'(seed[14:13]));
      if (seed[20:18] == 3'd0) poke(a, seed ^ 32'hA5A5_5A5A);
      op(seed[16], a, seed[22:21], {seed[7:0], seed[31:24], seed[15:0]}, "R6");
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

endmodule